// File: doc/BRIEF.md
# Directory Home Coherence Controller

This block is the home side of a directory-based invalidation protocol for one cache line that is shared by a parameterised number of clients. Each client owns three one-entry message buffers. The first carries requests towards the home. The second carries invalidates and grants back to the client. The third carries invalidate acknowledgements towards the home. The home holds one command at a time. When it accepts a command, it snapshots its sharer list. It then recalls every copy that would conflict with the request and waits for all the acknowledgements before it grants the line.

A simple client model sits beside the home so that the line can be exercised end to end. Each client turns a one-cycle request pulse into a message in its request buffer. It tracks its own line state, answers invalidates and installs grants. The requests the clients accept are legal ones. A client with no copy may ask for a shared copy. A client that does not already own the line may ask for exclusive ownership. Data, multiple addresses and memory timing are not modelled.

Top module: `coh_home_top`

## Requirements
- R1: During and right after reset, every client line reads invalid (code 0). The sharer list, the exclusive flag and the busy flag are all zero.
- R2: A client puts a request into its empty request buffer only when it has no request of its own outstanding. A shared request (request pulse with `req_excl_i` low) needs the line to be invalid. An exclusive request (`req_excl_i` high) needs the line to be anything but exclusive. Any other request pulse is dropped and changes no output. Line codes are: invalid 0, shared 1, exclusive 2.
- R3: The home holds at most one command. It accepts a new one only while `busy_o` is low. When several clients are waiting, the lowest-numbered client is taken first. A sharer bit can be added only while a command is held.
- R4: An exclusive request invalidates every client in the sharer list captured at acceptance. It is granted only after all of their acknowledgements have arrived. Afterwards the requester is the only sharer and the exclusive flag is set.
- R5: A shared request that arrives while exclusive ownership is granted invalidates the owner first. The shared grant follows that acknowledgement. The exclusive flag is set only by a grant, never while the home is idle.
- R6: A shared request with no exclusive owner is granted without disturbing the other sharers. The requester's sharer bit is added to the list.
- R7: A client that receives an invalidate drops its line to invalid and acknowledges. The acknowledgement removes its sharer bit. A client that holds any copy is always in the sharer list.
- R8: While any client holds the line exclusive, every other client holds it invalid.
- R9: Invalidates and grants to one client travel on the same buffer in order. A shared client that asks for exclusive is first invalidated and then granted, so it ends exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_CLIENTS | Per-client request pulse |
| req_excl_i | input | N_CLIENTS | Per-client request kind: 1 exclusive, 0 shared |
| line_o | output | 2*N_CLIENTS | Line state of client c in bits [2c+1:2c] (0 invalid, 1 shared, 2 exclusive) |
| sharer_o | output | N_CLIENTS | Home sharer list |
| excl_o | output | 1 | Exclusive ownership granted |
| busy_o | output | 1 | Home is holding a command |

## Verification
The bench drives several kinds of upgrade through the controller. A shared client asks for exclusive, which puts an invalidate and a grant on the same buffer back to back. A design that reordered them or dropped the grant would leave that client invalid or hung. An exclusive request that meets two sharers must wait for both acknowledgements. A design that granted on the first one would show two copies next to an exclusive line. In one step all the clients request at once, and the expected final owner checks lowest-index-first service. Illegal repeat requests are mixed in and must leave every output unchanged. A long random phase then compares a cycle-accurate behavioural model against every output on every cycle.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [2:0] {
    MSG_EMPTY   = 3'd0,
    MSG_REQ_SH  = 3'd1,
    MSG_REQ_EX  = 3'd2,
    MSG_INV     = 3'd3,
    MSG_INV_ACK = 3'd4,
    MSG_GNT_SH  = 3'd5,
    MSG_GNT_EX  = 3'd6
  } msg_e;

  typedef enum logic [1:0] {
    LINE_INV = 2'd0,
    LINE_SH  = 2'd1,
    LINE_EX  = 2'd2
  } line_e;
endpackage

// File: rtl/coh_pick.sv
module coh_pick #(
  parameter int N     = 4,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/coh_client.sv
module coh_client
  import coh_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  req_i,
  input  logic  req_excl_i,
  input  logic  ch1_pop_i,
  output msg_e  ch1_o,
  input  logic  ch2_push_i,
  input  msg_e  ch2_msg_i,
  output logic  ch2_empty_o,
  input  logic  ch3_pop_i,
  output logic  ch3_ack_o,
  output line_e line_o
);
  msg_e  ch1_q, ch2_q;
  logic  ch3_q, pend_q;
  line_e line_q;
  logic  issue_ok;

  assign issue_ok = req_i && (ch1_q == MSG_EMPTY) && !pend_q &&
                    (req_excl_i ? (line_q != LINE_EX) : (line_q == LINE_INV));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch1_q  <= MSG_EMPTY;
      ch2_q  <= MSG_EMPTY;
      ch3_q  <= 1'b0;
      pend_q <= 1'b0;
      line_q <= LINE_INV;
    end else begin
      if (issue_ok) begin
        ch1_q  <= req_excl_i ? MSG_REQ_EX : MSG_REQ_SH;
        pend_q <= 1'b1;
      end else if (ch1_pop_i) begin
        ch1_q <= MSG_EMPTY;
      end
      if (ch3_pop_i) ch3_q <= 1'b0;
      if (ch2_push_i) begin
        ch2_q <= ch2_msg_i;
      end else begin
        case (ch2_q)
          MSG_INV: if (!ch3_q) begin
            line_q <= LINE_INV;
            ch3_q  <= 1'b1;
            ch2_q  <= MSG_EMPTY;
          end
          MSG_GNT_SH: begin
            line_q <= LINE_SH;
            pend_q <= 1'b0;
            ch2_q  <= MSG_EMPTY;
          end
          MSG_GNT_EX: begin
            line_q <= LINE_EX;
            pend_q <= 1'b0;
            ch2_q  <= MSG_EMPTY;
          end
          default: ;
        endcase
      end
    end
  end

  assign ch1_o       = ch1_q;
  assign ch2_empty_o = (ch2_q == MSG_EMPTY);
  assign ch3_ack_o   = ch3_q;
  assign line_o      = line_q;
endmodule

// File: rtl/coh_home_ctrl.sv
module coh_home_ctrl
  import coh_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_vld_i,
  input  logic [N-1:0] req_ex_i,
  output logic [N-1:0] ch1_pop_o,
  input  logic [N-1:0] ch2_empty_i,
  output logic [N-1:0] ch2_push_o,
  output msg_e         ch2_msg_o [N],
  input  logic [N-1:0] ch3_ack_i,
  output logic [N-1:0] ch3_pop_o,
  output logic [N-1:0] sharer_o,
  output logic         excl_o,
  output logic         busy_o
);
  msg_e             cmd_q;
  logic [IDX_W-1:0] cur_q;
  logic [N-1:0]     sharer_q, inv_q;
  logic             exg_q;

  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;
  logic             accept, inv_phase, gnt_sh, gnt_ex, gnt;
  logic [N-1:0]     cur_oh, inv_send;

  coh_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
    .req_i (req_vld_i),
    .any_o (pick_any),
    .idx_o (pick_idx)
  );

  assign cur_oh    = N'(1) << cur_q;
  assign accept    = (cmd_q == MSG_EMPTY) && pick_any;
  assign inv_phase = (cmd_q == MSG_REQ_EX) || ((cmd_q == MSG_REQ_SH) && exg_q);
  assign inv_send  = inv_phase ? (inv_q & ch2_empty_i) : '0;
  assign gnt_sh    = (cmd_q == MSG_REQ_SH) && !exg_q && ch2_empty_i[cur_q];
  assign gnt_ex    = (cmd_q == MSG_REQ_EX) && (sharer_q == '0) && ch2_empty_i[cur_q];
  assign gnt       = gnt_sh || gnt_ex;

  assign ch1_pop_o  = accept ? (N'(1) << pick_idx) : '0;
  assign ch3_pop_o  = ch3_ack_i;
  assign ch2_push_o = inv_send | (gnt ? cur_oh : '0);

  always_comb begin
    for (int c = 0; c < N; c++) begin
      if (inv_send[c])  ch2_msg_o[c] = MSG_INV;
      else if (gnt_ex)  ch2_msg_o[c] = MSG_GNT_EX;
      else              ch2_msg_o[c] = MSG_GNT_SH;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= MSG_EMPTY;
      cur_q    <= '0;
      sharer_q <= '0;
      inv_q    <= '0;
      exg_q    <= 1'b0;
    end else begin
      if (accept) begin
        cmd_q <= req_ex_i[pick_idx] ? MSG_REQ_EX : MSG_REQ_SH;
        cur_q <= pick_idx;
        inv_q <= sharer_q;
      end else begin
        inv_q <= inv_q & ~inv_send;
      end
      // acks retire holders; a grant in the same cycle adds the requester
      if (gnt) begin
        sharer_q <= (sharer_q & ~ch3_ack_i) | cur_oh;
        cmd_q    <= MSG_EMPTY;
      end else begin
        sharer_q <= sharer_q & ~ch3_ack_i;
      end
      if (gnt_ex)          exg_q <= 1'b1;
      else if (|ch3_ack_i) exg_q <= 1'b0;
    end
  end

  assign sharer_o = sharer_q;
  assign excl_o   = exg_q;
  assign busy_o   = (cmd_q != MSG_EMPTY);
endmodule

// File: rtl/coh_home_top.sv
module coh_home_top
  import coh_pkg::*;
#(
  parameter int N_CLIENTS = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_CLIENTS-1:0]   req_i,
  input  logic [N_CLIENTS-1:0]   req_excl_i,
  output logic [2*N_CLIENTS-1:0] line_o,
  output logic [N_CLIENTS-1:0]   sharer_o,
  output logic                   excl_o,
  output logic                   busy_o
);
  localparam int IDX_W = (N_CLIENTS > 1) ? $clog2(N_CLIENTS) : 1;

  msg_e                 ch1_msg [N_CLIENTS];
  msg_e                 ch2_msg [N_CLIENTS];
  line_e                line_w  [N_CLIENTS];
  logic [N_CLIENTS-1:0] req_vld, req_ex, ch1_pop, ch2_empty, ch2_push, ch3_ack, ch3_pop;

  for (genvar g = 0; g < N_CLIENTS; g++) begin : g_cli
    coh_client u_cli (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_i       (req_i[g]),
      .req_excl_i  (req_excl_i[g]),
      .ch1_pop_i   (ch1_pop[g]),
      .ch1_o       (ch1_msg[g]),
      .ch2_push_i  (ch2_push[g]),
      .ch2_msg_i   (ch2_msg[g]),
      .ch2_empty_o (ch2_empty[g]),
      .ch3_pop_i   (ch3_pop[g]),
      .ch3_ack_o   (ch3_ack[g]),
      .line_o      (line_w[g])
    );
    assign req_vld[g]        = (ch1_msg[g] != MSG_EMPTY);
    assign req_ex[g]         = (ch1_msg[g] == MSG_REQ_EX);
    assign line_o[2*g +: 2]  = line_w[g];
  end

  coh_home_ctrl #(.N(N_CLIENTS), .IDX_W(IDX_W)) u_home (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_vld_i   (req_vld),
    .req_ex_i    (req_ex),
    .ch1_pop_o   (ch1_pop),
    .ch2_empty_i (ch2_empty),
    .ch2_push_o  (ch2_push),
    .ch2_msg_o   (ch2_msg),
    .ch3_ack_i   (ch3_ack),
    .ch3_pop_o   (ch3_pop),
    .sharer_o    (sharer_o),
    .excl_o      (excl_o),
    .busy_o      (busy_o)
  );
endmodule

// File: rtl/coh_home_chk.sv
module coh_home_chk #(
  parameter int N_CLIENTS = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [2*N_CLIENTS-1:0] line_o,
  input logic [N_CLIENTS-1:0]   sharer_o,
  input logic                   excl_o,
  input logic                   busy_o
);
  int n_ex, n_hold;

  always_comb begin
    n_ex   = 0;
    n_hold = 0;
    for (int c = 0; c < N_CLIENTS; c++) begin
      if (line_o[2*c +: 2] == 2'd2) n_ex++;
      if (line_o[2*c +: 2] != 2'd0) n_hold++;
    end
  end

  a_r8_excl_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_ex != 0) |-> (n_hold == 1));

  a_r4_excl_one_sharer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    excl_o |-> ($countones(sharer_o) == 1));

  a_r3_sharer_grows_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> ((sharer_o & ~$past(sharer_o)) == '0));

  a_r5_excl_set_by_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(excl_o) |-> $past(busy_o));

  for (genvar g = 0; g < N_CLIENTS; g++) begin : g_hold
    a_r7_holder_listed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (line_o[2*g +: 2] != 2'd0) |-> sharer_o[g]);
  end
endmodule

bind coh_home_top coh_home_chk #(.N_CLIENTS(N_CLIENTS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .line_o   (line_o),
  .sharer_o (sharer_o),
  .excl_o   (excl_o),
  .busy_o   (busy_o)
);

// File: tb/coh_home_tb_top.sv
`timescale 1ns/1ps
module coh_home_tb_top;
  localparam int N = 4;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [N-1:0]   req_i = '0, req_excl_i = '0;
  logic [2*N-1:0] line_o;
  logic [N-1:0]   sharer_o;
  logic           excl_o, busy_o;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  coh_home_top #(.N_CLIENTS(N)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .req_excl_i(req_excl_i),
    .line_o(line_o), .sharer_o(sharer_o), .excl_o(excl_o), .busy_o(busy_o)
  );

  // behavioural model; message codes: 0 none, 1 reqS, 2 reqE, 3 inv, 5 gntS, 6 gntE
  int m_line[N], m_pend[N], m_ch1[N], m_ch2[N], m_ch3[N], m_sh[N], m_inv[N];
  int m_cmd = 0, m_cur = 0, m_exg = 0;

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int cli(int c);
    return int'(line_o[2*c +: 2]);
  endfunction

  task automatic ref_step(logic [N-1:0] rq, logic [N-1:0] rx);
    int n_line[N], n_pend[N], n_ch1[N], n_ch2[N], n_ch3[N], n_sh[N], n_inv[N];
    int n_cmd, n_cur, n_exg, pick, all0;
    bit inv_phase, gsh, gex;
    n_line = m_line; n_pend = m_pend; n_ch1 = m_ch1; n_ch2 = m_ch2;
    n_ch3 = m_ch3; n_sh = m_sh; n_inv = m_inv;
    n_cmd = m_cmd; n_cur = m_cur; n_exg = m_exg;
    pick = -1; all0 = 1;
    for (int c = 0; c < N; c++) begin
      if (m_ch1[c] != 0 && pick < 0) pick = c;
      if (m_sh[c] != 0) all0 = 0;
    end
    inv_phase = (m_cmd == 2) || (m_cmd == 1 && m_exg != 0);
    gsh = (m_cmd == 1) && (m_exg == 0) && (m_ch2[m_cur] == 0);
    gex = (m_cmd == 2) && (all0 != 0) && (m_ch2[m_cur] == 0);
    for (int c = 0; c < N; c++) begin
      if (rq[c] && m_ch1[c] == 0 && m_pend[c] == 0 &&
          (rx[c] ? m_line[c] != 2 : m_line[c] == 0)) begin
        n_ch1[c] = rx[c] ? 2 : 1;
        n_pend[c] = 1;
      end
      if (inv_phase && m_inv[c] != 0 && m_ch2[c] == 0) begin
        n_ch2[c] = 3; n_inv[c] = 0;
      end else if ((gsh || gex) && c == m_cur) begin
        n_ch2[c] = gsh ? 5 : 6;
      end else if (m_ch2[c] == 3 && m_ch3[c] == 0) begin
        n_line[c] = 0; n_ch3[c] = 1; n_ch2[c] = 0;
      end else if (m_ch2[c] == 5 || m_ch2[c] == 6) begin
        n_line[c] = (m_ch2[c] == 5) ? 1 : 2; n_pend[c] = 0; n_ch2[c] = 0;
      end
      if (m_ch3[c] != 0) begin
        n_sh[c] = 0; n_exg = 0; n_ch3[c] = 0;
      end
    end
    if (m_cmd == 0 && pick >= 0) begin
      n_cmd = m_ch1[pick]; n_cur = pick; n_inv = m_sh; n_ch1[pick] = 0;
    end
    if (gsh || gex) begin
      n_sh[m_cur] = 1; n_cmd = 0;
      if (gex) n_exg = 1;
    end
    m_line = n_line; m_pend = n_pend; m_ch1 = n_ch1; m_ch2 = n_ch2;
    m_ch3 = n_ch3; m_sh = n_sh; m_inv = n_inv;
    m_cmd = n_cmd; m_cur = n_cur; m_exg = n_exg;
  endtask

  task automatic compare();
    int ex, hold;
    ex = 0; hold = 0;
    for (int c = 0; c < N; c++) begin
      chk($sformatf("R7 line of client %0d", c), cli(c), m_line[c]);
      chk($sformatf("R4 sharer bit %0d", c), int'(sharer_o[c]), m_sh[c]);
      if (cli(c) == 2) ex++;
      if (cli(c) != 0) hold++;
    end
    chk("R5 exclusive flag", int'(excl_o), m_exg);
    chk("R3 busy", int'(busy_o), (m_cmd != 0) ? 1 : 0);
    chk("R8 exclusive holder alone", (ex != 0 && hold != 1) ? 1 : 0, 0);
  endtask

  task automatic cyc(logic [N-1:0] rq, logic [N-1:0] rx);
    @(negedge clk_i);
    compare();
    req_i = rq; req_excl_i = rx;
    ref_step(rq, rx);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc('0, '0);
  endtask

  initial begin
    for (int c = 0; c < N; c++) begin
      m_line[c] = 0; m_pend[c] = 0; m_ch1[c] = 0; m_ch2[c] = 0;
      m_ch3[c] = 0; m_sh[c] = 0; m_inv[c] = 0;
    end
    repeat (3) @(negedge clk_i);
    chk("R1 lines after reset", int'(line_o), 0);
    chk("R1 sharers after reset", int'(sharer_o), 0);
    chk("R1 excl after reset", int'(excl_o), 0);
    chk("R1 busy after reset", int'(busy_o), 0);
    rst_ni = 1'b1;

    // R6: two shared readers
    cyc(4'b0001, 4'b0000); idle(15);
    cyc(4'b0010, 4'b0000); idle(15);
    chk("R6 two sharers", int'(sharer_o), 3);
    chk("R6 lines", cli(0) * 10 + cli(1), 11);
    // R2: shared client asks shared again -> dropped
    cyc(4'b0001, 4'b0000); idle(10);
    chk("R2 illegal repeat ignored busy", int'(busy_o), 0);
    chk("R2 illegal repeat ignored sharers", int'(sharer_o), 3);
    // R4: exclusive over two sharers
    cyc(4'b0100, 4'b0100); idle(20);
    chk("R4 owner exclusive", cli(2), 2);
    chk("R4 old sharers invalid", cli(0) + cli(1), 0);
    chk("R4 sharer list", int'(sharer_o), 4);
    chk("R4 excl flag", int'(excl_o), 1);
    // R5: shared request recalls the owner
    cyc(4'b0001, 4'b0000); idle(20);
    chk("R5 reader shared", cli(0), 1);
    chk("R5 owner invalid", cli(2), 0);
    chk("R5 excl flag cleared", int'(excl_o), 0);
    // R9: upgrade from shared
    cyc(4'b0001, 4'b0001); idle(20);
    chk("R9 upgrade ends exclusive", cli(0), 2);
    chk("R9 sharer list", int'(sharer_o), 1);
    // R2: owner asks exclusive again -> dropped
    cyc(4'b0001, 4'b0001); idle(10);
    chk("R2 owner repeat ignored", cli(0), 2);
    // R3: simultaneous exclusive requests, lowest served first, client 3 last
    cyc(4'b1110, 4'b1110); idle(60);
    chk("R3 last served owns line", cli(3), 2);
    chk("R3 others invalid", cli(0) + cli(1) + cli(2), 0);
    chk("R3 idle afterwards", int'(busy_o), 0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [N-1:0] rq, rx;
      rq = N'($urandom_range(0, 15)) & N'($urandom_range(0, 15));
      rx = N'($urandom_range(0, 15));
      cyc(rq, rx);
    end
    idle(80);
    chk("R3 drains to idle", int'(busy_o), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL R3 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule